// File: doc/BRIEF.md
# TMDS Lane Aligner and Expander

This block sits between a word FIFO and a high-speed output serializer. It holds each incoming 32-bit word in its own rotating register. Depending on a mode bit that travels with the word, it sends out a number of beats per word. A raw word produces copies of the register, rotated between beats. An encode word produces, on each beat, three 10-bit TMDS symbols that carry three colour fields.

In encode mode each lane rotates the current register right by its own amount, so that the wanted field's most significant bit sits at bit 7. It then keeps the top 1 to 8 bits, clears the rest and TMDS-encodes the byte. Each lane keeps its own running disparity. Raw and encode words have separate per-beat rotate amounts and beat counts, so several packed pixels can be unpacked from one word. When the block is disabled, every word passes through unchanged as a single beat, and the disparity counters are held at zero.

Top module: `tmds_xp_top`

## Requirements
- R1: After a synchronous reset `out_valid` is 0 and `in_ready` is 1.
- R2: With `cfg_expand_en` = 0, each accepted word appears once on `out_data`, unchanged and in order, whatever the mode bit and count fields hold.
- R3: A raw word (`in_mode` = 0) yields `cfg_raw_count` beats, where 0 means 32. Beat i carries the word rotated right by i times `cfg_raw_shift`.
- R4: An encode word (`in_mode` = 1) yields `cfg_enc_count` beats, where 0 means 32. Beat i works on the word rotated right by i times `cfg_enc_shift`.
- R5: The field of lane L is bits 7:0 of the beat's register rotated right by `cfg_lane_rot[5L+4:5L]`. The top w+1 bits are kept and the low 7-w bits are forced to zero, where w = `cfg_lane_bits[3L+2:3L]`.
- R6: Each lane field is encoded with the DVI TMDS rules. Transition minimisation uses XOR (bit 8 = 1) or XNOR (bit 8 = 0). DC balancing uses a running disparity per lane, updated only on encode beats.
- R7: An encode beat packs lane 0 in `out_data[9:0]`, lane 1 in [19:10] and lane 2 in [29:20], and drives [31:30] to zero.
- R8: While `cfg_expand_en` is 0 the running disparities are cleared. After the block is re-enabled, encoding restarts as it does from reset.
- R9: While `out_valid` = 1 and `out_ready` = 0, `out_data` holds its value, and no beat is dropped or repeated.
- R10: `in_ready` is high in the cycle in which the last beat of a word is taken, so single-beat words stream at one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_expand_en | input | 1 | Expander enable; 0 gives pass-through |
| cfg_raw_shift | input | 5 | Right-rotate per raw beat |
| cfg_raw_count | input | 5 | Beats per raw word (0 = 32) |
| cfg_enc_shift | input | 5 | Right-rotate per encode beat |
| cfg_enc_count | input | 5 | Beats per encode word (0 = 32) |
| cfg_lane_rot | input | 15 | Per-lane field rotate, lane L at [5L+4:5L] |
| cfg_lane_bits | input | 9 | Per-lane width minus one, lane L at [3L+2:3L] |
| in_valid | input | 1 | Input word valid |
| in_mode | input | 1 | 0 raw, 1 encode |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Block takes the word this cycle |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 32 | Output beat |
| out_ready | input | 1 | Serializer accepts the beat |

## Verification
Two events can fall in the same clock: the last beat of one word leaves the rotating register, and the next word is loaded into it. A downstream stall can also land on that same edge. The bench provokes both by streaming back-to-back words while `out_ready` toggles randomly, and by sending a burst of single-beat words with `out_ready` held high. A scoreboard judges the result. It matches every beat against a model computed independently of the RTL, and it times the burst, which must finish in close to one clock per word.

// File: rtl/tmds_xp_pkg.sv
package tmds_xp_pkg;
  localparam int LANES   = 3;
  localparam int SYM_W   = 10;
  localparam int FLD_W   = 8;
  localparam int DISP_W  = 6;

  typedef enum logic {
    BEAT_RAW = 1'b0,
    BEAT_ENC = 1'b1
  } beat_kind_e;
endpackage

// File: rtl/tmds_xp_feed.sv
module tmds_xp_feed
  import tmds_xp_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SHW   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              in_valid,
  input  logic              in_mode,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [SHW-1:0]    raw_shift,
  input  logic [SHW-1:0]    raw_count,
  input  logic [SHW-1:0]    enc_shift,
  input  logic [SHW-1:0]    enc_count,
  input  logic              adv,
  output logic              beat_valid,
  output beat_kind_e        beat_kind,
  output logic [DATA_W-1:0] beat_word
);
  logic [DATA_W-1:0] sr_q;
  logic              busy_q;
  beat_kind_e        kind_q;
  logic [SHW:0]      left_q;
  logic [SHW:0]      load_cnt;
  logic [SHW-1:0]    load_field;
  logic [SHW-1:0]    step_amt;
  logic [DATA_W-1:0] sr_next;
  logic              fire, last, take;

  assign beat_valid = busy_q;
  assign beat_kind  = kind_q;
  assign beat_word  = sr_q;
  assign fire       = busy_q && adv;
  assign last       = (left_q == (SHW+1)'(1));
  assign in_ready   = !busy_q || (fire && last);
  assign take       = in_valid && in_ready;

  always_comb begin
    load_field = in_mode ? enc_count : raw_count;
    if (!en)
      load_cnt = (SHW+1)'(1);
    else if (load_field == '0)
      load_cnt = (SHW+1)'(DATA_W);
    else
      load_cnt = {1'b0, load_field};
    step_amt = (kind_q == BEAT_ENC) ? enc_shift : raw_shift;
    sr_next  = (sr_q >> step_amt) | (sr_q << (DATA_W - int'(step_amt)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      busy_q <= 1'b0;
      kind_q <= BEAT_RAW;
      left_q <= '0;
    end else if (take) begin
      sr_q   <= in_data;
      busy_q <= 1'b1;
      kind_q <= (en && in_mode) ? BEAT_ENC : BEAT_RAW;
      left_q <= load_cnt;
    end else if (fire) begin
      sr_q   <= sr_next;
      left_q <= left_q - (SHW+1)'(1);
      if (last) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmds_xp_lane.sv
module tmds_xp_lane
  import tmds_xp_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SHW   = $clog2(DATA_W)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     step,
  input  logic [DATA_W-1:0]        word,
  input  logic [SHW-1:0]           rot,
  input  logic [2:0]               nbits,
  output logic [SYM_W-1:0]         sym,
  output logic signed [DISP_W-1:0] disp_o
);
  logic [DATA_W-1:0]        rotated;
  logic [FLD_W-1:0]         mask, fld, qm;
  logic                     use_xnor, qm8;
  logic [3:0]               n1d, n1q;
  logic signed [DISP_W-1:0] disp_q, disp_d, bal, two_if;

  always_comb begin
    rotated  = (word >> rot) | (word << (DATA_W - int'(rot)));
    mask     = 8'hFF << (3'd7 - nbits);
    fld      = rotated[FLD_W-1:0] & mask;
    n1d      = 4'($countones(fld));
    use_xnor = (n1d > 4'd4) || (n1d == 4'd4 && !fld[0]);
    qm8      = !use_xnor;
    qm[0]    = fld[0];
    for (int i = 1; i < FLD_W; i++)
      qm[i] = use_xnor ? ~(qm[i-1] ^ fld[i]) : (qm[i-1] ^ fld[i]);
    n1q      = 4'($countones(qm));
    bal      = DISP_W'(2 * int'(n1q) - 8);
    two_if   = DISP_W'(2);
    if (disp_q == 0 || n1q == 4'd4) begin
      sym    = {~qm8, qm8, (qm8 ? qm : ~qm)};
      disp_d = qm8 ? (disp_q + bal) : (disp_q - bal);
    end else if ((disp_q > 0 && n1q > 4'd4) || (disp_q < 0 && n1q < 4'd4)) begin
      sym    = {1'b1, qm8, ~qm};
      disp_d = qm8 ? (disp_q + two_if - bal) : (disp_q - bal);
    end else begin
      sym    = {1'b0, qm8, qm};
      disp_d = qm8 ? (disp_q + bal) : (disp_q - two_if + bal);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      disp_q <= '0;
    else if (step)
      disp_q <= disp_d;
  end

  assign disp_o = disp_q;
endmodule

// File: rtl/tmds_xp_top.sv
module tmds_xp_top
  import tmds_xp_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SHW   = $clog2(DATA_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_expand_en,
  input  logic [SHW-1:0]       cfg_raw_shift,
  input  logic [SHW-1:0]       cfg_raw_count,
  input  logic [SHW-1:0]       cfg_enc_shift,
  input  logic [SHW-1:0]       cfg_enc_count,
  input  logic [LANES*SHW-1:0] cfg_lane_rot,
  input  logic [LANES*3-1:0]   cfg_lane_bits,
  input  logic                 in_valid,
  input  logic                 in_mode,
  input  logic [DATA_W-1:0]    in_data,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_data,
  input  logic                 out_ready
);
  localparam int PAD_W = DATA_W - LANES * SYM_W;

  logic                     adv, beat_valid, enc_step;
  beat_kind_e               beat_kind;
  logic [DATA_W-1:0]        sr_w, next_data;
  logic [LANES*SYM_W-1:0]   syms;
  logic [LANES*DISP_W-1:0]  disp_all;

  assign adv      = !out_valid || out_ready;
  assign enc_step = beat_valid && adv && (beat_kind == BEAT_ENC);

  tmds_xp_feed #(.DATA_W(DATA_W)) feed_i (
    .clk(clk), .rst(rst), .en(cfg_expand_en),
    .in_valid(in_valid), .in_mode(in_mode), .in_data(in_data), .in_ready(in_ready),
    .raw_shift(cfg_raw_shift), .raw_count(cfg_raw_count),
    .enc_shift(cfg_enc_shift), .enc_count(cfg_enc_count),
    .adv(adv), .beat_valid(beat_valid), .beat_kind(beat_kind), .beat_word(sr_w)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [DISP_W-1:0] disp_l;
    tmds_xp_lane #(.DATA_W(DATA_W)) lane_i (
      .clk(clk), .rst(rst), .clr(!cfg_expand_en), .step(enc_step),
      .word(sr_w),
      .rot(cfg_lane_rot[l*SHW +: SHW]),
      .nbits(cfg_lane_bits[l*3 +: 3]),
      .sym(syms[l*SYM_W +: SYM_W]),
      .disp_o(disp_l)
    );
    assign disp_all[l*DISP_W +: DISP_W] = disp_l;
  end

  assign next_data = (beat_kind == BEAT_ENC) ? {{PAD_W{1'b0}}, syms} : sr_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= beat_valid;
      if (beat_valid) out_data <= next_data;
    end
  end
endmodule

// File: rtl/tmds_xp_chk.sv
module tmds_xp_chk
  import tmds_xp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [DATA_W-1:0]       in_data,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [DATA_W-1:0]       out_data,
  input logic [DATA_W-1:0]       sr_word,
  input logic [LANES*DISP_W-1:0] disp_all
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R6
  disp_even_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_all[0] | disp_all[DISP_W] | disp_all[2*DISP_W]) == 1'b0);

  // R8
  disp_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> disp_all == '0);

  // R2
  word_load_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> sr_word == $past(in_data));
endmodule

bind tmds_xp_top tmds_xp_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .en(cfg_expand_en),
  .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .sr_word(sr_w), .disp_all(disp_all)
);

// File: tb/tmds_xp_top_tb_top.sv
module tmds_xp_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_expand_en = 1'b0;
  logic [4:0]  cfg_raw_shift = '0, cfg_raw_count = 5'd1;
  logic [4:0]  cfg_enc_shift = '0, cfg_enc_count = 5'd1;
  logic [14:0] cfg_lane_rot = '0;
  logic [8:0]  cfg_lane_bits = '0;
  logic        in_valid = 1'b0, in_mode = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, out_ready = 1'b1;
  logic [31:0] out_data;

  int          nvec = 0, nfail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  string       cur_tag = "R2";
  int          mdisp[3];
  bit          rand_ready = 1'b0;
  int          cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  tmds_xp_top dut_i (
    .clk(clk), .rst(rst), .cfg_expand_en(cfg_expand_en),
    .cfg_raw_shift(cfg_raw_shift), .cfg_raw_count(cfg_raw_count),
    .cfg_enc_shift(cfg_enc_shift), .cfg_enc_count(cfg_enc_count),
    .cfg_lane_rot(cfg_lane_rot), .cfg_lane_bits(cfg_lane_bits),
    .in_valid(in_valid), .in_mode(in_mode), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  function automatic logic [31:0] rotr(logic [31:0] w, int s);
    if (s == 0) return w;
    return (w >> s) | (w << (32 - s));
  endfunction

  function automatic logic [7:0] pick(logic [31:0] w, int rot, int nb);
    logic [31:0] r = rotr(w, rot);
    logic [7:0]  m = '0;
    for (int b = 0; b <= nb; b++) m[7-b] = 1'b1;
    return r[7:0] & m;
  endfunction

  function automatic logic [9:0] tmds_model(logic [7:0] d, int lane);
    int ones = 0, q1 = 0, q0;
    logic [8:0] q;
    logic [9:0] o;
    bit xn;
    for (int b = 0; b < 8; b++) ones += d[b];
    xn = (ones > 4) || (ones == 4 && d[0] == 1'b0);
    q[0] = d[0];
    for (int b = 1; b < 8; b++) q[b] = xn ? !(q[b-1] ^ d[b]) : (q[b-1] ^ d[b]);
    q[8] = !xn;
    for (int b = 0; b < 8; b++) q1 += q[b];
    q0 = 8 - q1;
    if (mdisp[lane] == 0 || q1 == q0) begin
      o = {!q[8], q[8], q[8] ? q[7:0] : ~q[7:0]};
      mdisp[lane] += q[8] ? (q1 - q0) : (q0 - q1);
    end else if ((mdisp[lane] > 0 && q1 > q0) || (mdisp[lane] < 0 && q0 > q1)) begin
      o = {1'b1, q[8], ~q[7:0]};
      mdisp[lane] += (q[8] ? 2 : 0) + q0 - q1;
    end else begin
      o = {1'b0, q[8], q[7:0]};
      mdisp[lane] += -(q[8] ? 0 : 2) + q1 - q0;
    end
    return o;
  endfunction

  task automatic send(logic [31:0] w, logic mode);
    int n, sh;
    logic [31:0] cur = w;
    logic [31:0] e;
    if (!cfg_expand_en) begin
      n = 1; sh = 0;
    end else begin
      n  = mode ? int'(cfg_enc_count) : int'(cfg_raw_count);
      sh = mode ? int'(cfg_enc_shift) : int'(cfg_raw_shift);
      if (n == 0) n = 32;
    end
    for (int i = 0; i < n; i++) begin
      if (cfg_expand_en && mode) begin
        e = '0;
        for (int l = 0; l < 3; l++)
          e[l*10 +: 10] = tmds_model(pick(cur, int'(cfg_lane_rot[l*5 +: 5]),
                                          int'(cfg_lane_bits[l*3 +: 3])), l);
      end else begin
        e = cur;
      end
      exp_q.push_back(e);
      tag_q.push_back(cur_tag);
      cur = rotr(cur, sh);
    end
    @(negedge clk);
    in_valid = 1'b1; in_data = w; in_mode = mode;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_enable(logic v);
    drain();
    cfg_expand_en = v;
    if (!v) for (int l = 0; l < 3; l++) mdisp[l] = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check1(string tag, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      out_ready = rand_ready ? 1'($urandom % 2) : 1'b1;
      if (!rst && out_valid && out_ready) begin
        if (exp_q.size() == 0) check1("R9 unexpected beat", out_data, 32'hx);
        else check1(tag_q.pop_front(), out_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int t0;
    for (int l = 0; l < 3; l++) mdisp[l] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R1: reset state
    check1("R1 out_valid", {31'b0, out_valid}, 32'd0);
    check1("R1 in_ready", {31'b0, in_ready}, 32'd1);

    // R2: pass-through while disabled; count fields are ignored
    cur_tag = "R2";
    cfg_raw_count = 5'd7; cfg_enc_count = 5'd3; cfg_raw_shift = 5'd4;
    send(32'h0123_4567, 1'b0);
    send(32'h89AB_CDEF, 1'b1);
    send(32'hFFFF_0000, 1'b0);
    send(32'h0000_0001, 1'b1);

    // R3: raw beats with rotation, and count 0 = 32
    set_enable(1'b1);
    cur_tag = "R3";
    cfg_raw_shift = 5'd8; cfg_raw_count = 5'd4;
    send(32'hDEAD_BEEF, 1'b0);
    send(32'h1234_5678, 1'b0);
    drain();
    cfg_raw_shift = 5'd1; cfg_raw_count = 5'd0;
    send(32'h8000_0003, 1'b0);

    // R4 R5 R7: packed 16-bit pixels, two per word
    drain();
    cur_tag = "R5";
    cfg_lane_rot  = {5'd8, 5'd3, 5'd29};
    cfg_lane_bits = {3'd4, 3'd5, 3'd4};
    cfg_enc_shift = 5'd16; cfg_enc_count = 5'd2;
    send(32'hF800_07E0, 1'b1);
    send(32'h001F_FFFF, 1'b1);
    send(32'hA5A5_5A5A, 1'b1);
    cur_tag = "R7";
    send(32'h1234_CDEF, 1'b1);
    send(32'hFFFF_FFFF, 1'b1);

    // R4 R6: full bytes, four per word
    drain();
    cur_tag = "R6";
    cfg_lane_rot  = {5'd16, 5'd8, 5'd0};
    cfg_lane_bits = {3'd7, 3'd7, 3'd7};
    cfg_enc_shift = 5'd8; cfg_enc_count = 5'd4;
    send(32'h0000_0000, 1'b1);
    send(32'hFFFF_FFFF, 1'b1);
    send(32'h10F0_8001, 1'b1);
    send(32'h7E3C_C3E7, 1'b1);
    cur_tag = "R4";
    send(32'h5555_AAAA, 1'b0);
    send(32'h0F1E_2D3C, 1'b1);

    // R8: disable clears disparity, then replay from a clean state
    set_enable(1'b0);
    cur_tag = "R8";
    send(32'hCAFE_F00D, 1'b1);
    set_enable(1'b1);
    send(32'h10F0_8001, 1'b1);
    send(32'h7E3C_C3E7, 1'b1);

    // R9: random downstream stalls, mixed words
    drain();
    cur_tag = "R9";
    rand_ready = 1'b1;
    cfg_raw_shift = 5'd3; cfg_raw_count = 5'd2;
    cfg_enc_count = 5'd3;
    for (int k = 0; k < 30; k++)
      send($urandom, 1'($urandom % 2));
    drain();
    rand_ready = 1'b0;

    // R10: single-beat words back to back
    cfg_enc_count = 5'd1; cfg_raw_count = 5'd1;
    cur_tag = "R10";
    t0 = cyc;
    for (int k = 0; k < 20; k++)
      send(32'h0101_0101 * k, 1'(k % 2));
    while (exp_q.size() != 0) @(negedge clk);
    check1("R10 cycles", ((cyc - t0) <= 24) ? 32'd1 : 32'd0, 32'd1);

    drain();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule